// File: doc/BRIEF.md
# Late-Write Synchronous Memory Front End

This block is a single-port synchronous memory with a write path that runs one cycle behind its address. Address, select, write enable and byte enables are taken on the rising clock edge. For a write, the data word follows on the next rising edge and is parked in a one-entry write buffer. The parked entry moves into the storage array only when the data of a later write arrives to take its place. Reads take their address on a rising edge and present their data from the falling edge half a cycle later.

Reads always see the latest write. The read path compares its address with the parked entry. On a hit, it takes each byte lane from the entry if that lane was enabled in the write, and from the array otherwise. The word is 36 bits wide, made of four 9-bit lanes, and the address width is a parameter.

The interface has no back-pressure. An operation is accepted on every rising edge where select is high. The read result comes with `rd_valid`, which is high for exactly one clock period. The consumer has to take the word in that window, because no ready input exists to hold it.

Top module: `lw_sram_front`

## Requirements
- R1: `cs`, `we`, `addr` and `byte_en` are used only as sampled at a rising clock edge; changing them after that edge does not change the read result for the operation that edge took.
- R2: A write is taken when `cs`=1 and `we`=1 at a rising edge. Its data is the value of `wr_data` at the next rising edge. The value of `wr_data` at the address edge is ignored.
- R3: The write buffer holds one write. That write is committed to the array at the rising edge where the data of the next write is captured, and it is not lost while it waits.
- R4: A read is taken when `cs`=1 and `we`=0 at a rising edge. `rd_valid` and `rd_data` update at the falling edge that follows and hold for one clock period. Before that falling edge they still show the previous result.
- R5: A read of the address held in the write buffer returns the buffered lanes whose byte enable was 1, and the array lanes for the rest.
- R6: `byte_en[i]` enables lane i, which is `wr_data[9*i+8:9*i]`. A lane whose enable is 0 keeps its old contents.
- R7: After a rising edge with `cs`=0, or with a write, `rd_valid` is 0 and `rd_data` is all zeros from the following falling edge for one period.
- R8: While `rst_n` is low, and after it is released until the first read completes, `rd_valid` is 0 and `rd_data` is 0.
- R9: Writes on consecutive cycles, and a read issued in the cycle right after a write's address, all return the newest data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; control is taken on the rising edge, read data is launched on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Select; 0 means deselect |
| we | input | 1 | 1 = write, 0 = read (when `cs`=1) |
| addr | input | ADDR_W | Word address |
| byte_en | input | LANES | Per-lane write enable, bit i for lane i |
| wr_data | input | LANES*LANE_W | Write data, sampled one edge after its address |
| rd_data | output | LANES*LANE_W | Read data; zero when not valid |
| rd_valid | output | 1 | High for one period when `rd_data` carries a read result |

## Verification
A read that is sampled at rising edge N has its result due at the falling edge of the same cycle, half a period later. The bench therefore checks right after edge N that the output still shows the previous result. It checks again just after the falling edge that the new word and `rd_valid` are present. Write data is due at edge N+1 after an address at edge N. The bench drives a junk value on `wr_data` during the address cycle and the real word in the following cycle, so a wrong capture edge shows up in the readback. Deselect and write cycles are checked at the falling edge after the edge that took them, where `rd_valid` and `rd_data` must both be zero.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  localparam int LANES_DEF  = 4;
  localparam int LANE_W_DEF = 9;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/lw_ctrl_stage.sv
module lw_ctrl_stage #(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [LANES-1:0]     byte_en,
  output lw_sram_pkg::op_e     op_q,
  output logic [AW-1:0]        addr_q,
  output logic [LANES-1:0]     be_q
);
  import lw_sram_pkg::*;

  op_e op_d;

  always_comb begin
    if (!cs)     op_d = OP_IDLE;
    else if (we) op_d = OP_WRITE;
    else         op_d = OP_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      addr_q <= '0;
      be_q   <= '0;
    end else begin
      op_q   <= op_d;
      addr_q <= addr;
      be_q   <= byte_en;
    end
  end
endmodule

// File: rtl/lw_wbuf.sv
module lw_wbuf #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [AW-1:0]     ld_addr,
  input  logic [LANES-1:0]  ld_be,
  input  logic [DW-1:0]     ld_data,
  output logic              buf_v,
  output logic [AW-1:0]     buf_addr,
  output logic [LANES-1:0]  buf_be,
  output logic [DW-1:0]     buf_data,
  output logic              commit
);
  // The parked write leaves for the array only when a newer one replaces it.
  assign commit = load && buf_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_v    <= 1'b0;
      buf_addr <= '0;
      buf_be   <= '0;
      buf_data <= '0;
    end else if (load) begin
      buf_v    <= 1'b1;
      buf_addr <= ld_addr;
      buf_be   <= ld_be;
      buf_data <= ld_data;
    end
  end
endmodule

// File: rtl/lw_array.sv
module lw_array #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              wen,
  input  logic [AW-1:0]     waddr,
  input  logic [LANES-1:0]  wbe,
  input  logic [DW-1:0]     wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DW-1:0]     rdata
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wen && wbe[l]) mem[waddr] <= wdata[l*LANE_W +: LANE_W];
    end

    assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/lw_rd_out.sv
module lw_rd_out #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [AW-1:0]     raddr,
  input  logic [DW-1:0]     arr_data,
  input  logic              buf_v,
  input  logic [AW-1:0]     buf_addr,
  input  logic [LANES-1:0]  buf_be,
  input  logic [DW-1:0]     buf_data,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid
);
  logic          hit;
  logic [DW-1:0] merged;

  assign hit = buf_v && (buf_addr == raddr);

  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign merged[l*LANE_W +: LANE_W] = (hit && buf_be[l]) ?
        buf_data[l*LANE_W +: LANE_W] : arr_data[l*LANE_W +: LANE_W];
  end

  // Launched on the falling edge, half a period after the address edge.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      rd_data  <= rd_req ? merged : '0;
    end
  end
endmodule

// File: rtl/lw_sram_front.sv
module lw_sram_front #(
  parameter int ADDR_W  = 6,
  parameter int LANES   = lw_sram_pkg::LANES_DEF,
  parameter int LANE_W  = lw_sram_pkg::LANE_W_DEF,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  byte_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  import lw_sram_pkg::*;

  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  be_q;
  logic              pend_v;
  logic              rd_req;
  logic              buf_v;
  logic [ADDR_W-1:0] buf_addr;
  logic [LANES-1:0]  buf_be;
  logic [DATA_W-1:0] buf_data;
  logic              commit;
  logic [DATA_W-1:0] arr_data;

  lw_ctrl_stage #(.AW(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .byte_en(byte_en),
    .op_q(op_q), .addr_q(addr_q), .be_q(be_q)
  );

  assign pend_v = (op_q == OP_WRITE);
  assign rd_req = (op_q == OP_READ);

  lw_wbuf #(.AW(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .load(pend_v), .ld_addr(addr_q), .ld_be(be_q),
    .ld_data(wr_data), .buf_v(buf_v), .buf_addr(buf_addr), .buf_be(buf_be),
    .buf_data(buf_data), .commit(commit)
  );

  lw_array #(.AW(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .wen(commit), .waddr(buf_addr), .wbe(buf_be), .wdata(buf_data),
    .raddr(addr_q), .rdata(arr_data)
  );

  lw_rd_out #(.AW(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .raddr(addr_q), .arr_data(arr_data),
    .buf_v(buf_v), .buf_addr(buf_addr), .buf_be(buf_be), .buf_data(buf_data),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/lw_sram_front_chk.sv
module lw_sram_front_chk #(
  parameter int AW = 6,
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          we,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] rd_data,
  input logic          rd_valid,
  input logic          pend_v,
  input logic [AW-1:0] pend_addr,
  input logic          buf_v,
  input logic [AW-1:0] buf_addr
);
  // R2: a write address edge leaves a pending write holding that address
  a_r2_pend_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we) |=> (pend_v && pend_addr == $past(addr)));

  // R3: the pending write lands in the one-entry buffer on the data edge
  a_r3_buffer_load: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v |=> (buf_v && buf_addr == $past(pend_addr)));

  // R4: a read edge gives a valid result by the next rising edge
  a_r4_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !we) |=> rd_valid);

  // R7: deselect or write edges give no valid result
  a_r7_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && !we) |=> !rd_valid);

  // R7: the output is zero whenever it is not valid
  a_r7_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0));
endmodule

bind lw_sram_front lw_sram_front_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr),
  .rd_data(rd_data), .rd_valid(rd_valid), .pend_v(pend_v),
  .pend_addr(addr_q), .buf_v(buf_v), .buf_addr(buf_addr)
);

// File: tb/tb_lw_sram_front.sv
module tb_lw_sram_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [3:0]  byte_en = '0;
  logic [35:0] wr_data = '0;
  logic [35:0] rd_data;
  logic        rd_valid;

  int n_chk = 0;
  int n_bad = 0;
  logic [35:0] model [64];
  localparam logic [35:0] JUNK = 36'hBAD_BAD_BAD;

  lw_sram_front dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr),
    .byte_en(byte_en), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives one operation; returns 1 ns after the rising edge that took it.
  task automatic step(input logic s, input logic w, input logic [5:0] a,
                      input logic [3:0] b, input logic [35:0] d);
    cs = s; we = w; addr = a; byte_en = b; wr_data = d;
    @(posedge clk); #1;
  endtask

  task automatic mupd(input logic [5:0] a, input logic [3:0] b, input logic [35:0] d);
    for (int l = 0; l < 4; l++)
      if (b[l]) model[a][l*9 +: 9] = d[l*9 +: 9];
  endtask

  task automatic after_fall;
    @(negedge clk); #1;
  endtask

  task automatic t_reset;
    #3;
    check("R8 rd_valid in reset", {35'd0, rd_valid}, 36'd0);
    check("R8 rd_data in reset", rd_data, 36'd0);
    @(posedge clk); #1; rst_n = 1'b1;
    step(1'b0, 1'b0, 6'd0, 4'h0, '0);
    after_fall;
    check("R8 rd_valid after release", {35'd0, rd_valid}, 36'd0);
    check("R8 rd_data after release", rd_data, 36'd0);
  endtask

  task automatic t_single;
    step(1'b1, 1'b1, 6'd5, 4'hF, JUNK);          // address edge, junk data ignored
    step(1'b0, 1'b0, 6'd0, 4'h0, 36'h123456789); // data edge
    mupd(6'd5, 4'hF, 36'h123456789);
    step(1'b1, 1'b0, 6'd5, 4'h0, JUNK);          // read address edge
    check("R4 not yet valid before fall", {35'd0, rd_valid}, 36'd0);
    after_fall;
    check("R4 rd_valid at fall", {35'd0, rd_valid}, 36'd1);
    check("R2 data from edge after address", rd_data, model[5]);
  endtask

  task automatic t_coherent;
    step(1'b1, 1'b1, 6'd9, 4'hF, JUNK);
    step(1'b1, 1'b1, 6'd10, 4'hF, 36'hAAAA_BBBB_C);
    mupd(6'd9, 4'hF, 36'hAAAA_BBBB_C);
    step(1'b1, 1'b1, 6'd9, 4'b0101, 36'h0FEDC_BA98);  // commits addr 9 full word
    mupd(6'd10, 4'hF, 36'h0FEDC_BA98);
    step(1'b1, 1'b0, 6'd9, 4'h0, 36'h111_222_333);   // data for partial write, read 9
    mupd(6'd9, 4'b0101, 36'h111_222_333);
    after_fall;
    check("R5 buffer hit merges enabled lanes", rd_data, model[9]);
    step(1'b1, 1'b1, 6'd11, 4'hF, JUNK);
    step(1'b1, 1'b0, 6'd9, 4'h0, 36'h5555_6666_7); // commits partial write to array
    mupd(6'd11, 4'hF, 36'h5555_6666_7);
    after_fall;
    check("R3 R6 committed partial write keeps lanes", rd_data, model[9]);
    step(1'b1, 1'b0, 6'd10, 4'h0, JUNK);
    after_fall;
    check("R3 earlier write read from array", rd_data, model[10]);
  endtask

  task automatic t_back_to_back;
    step(1'b1, 1'b1, 6'd20, 4'hF, JUNK);
    step(1'b1, 1'b1, 6'd21, 4'hF, 36'h0_2020_2020);
    step(1'b1, 1'b1, 6'd22, 4'hF, 36'h0_2121_2121);
    step(1'b1, 1'b1, 6'd23, 4'hF, 36'h0_2222_2222);
    step(1'b1, 1'b0, 6'd23, 4'h0, 36'h0_2323_2323);
    mupd(6'd20, 4'hF, 36'h0_2020_2020);
    mupd(6'd21, 4'hF, 36'h0_2121_2121);
    mupd(6'd22, 4'hF, 36'h0_2222_2222);
    mupd(6'd23, 4'hF, 36'h0_2323_2323);
    after_fall;
    check("R9 read in data cycle of last write", rd_data, model[23]);
    for (int a = 20; a < 23; a++) begin
      step(1'b1, 1'b0, 6'(a), 4'h0, JUNK);
      after_fall;
      check("R9 back-to-back write kept", rd_data, model[a]);
    end
  endtask

  task automatic t_deselect;
    step(1'b0, 1'b0, 6'd20, 4'h0, JUNK);
    after_fall;
    check("R7 rd_valid after deselect", {35'd0, rd_valid}, 36'd0);
    check("R7 rd_data after deselect", rd_data, 36'd0);
    step(1'b1, 1'b1, 6'd30, 4'hF, JUNK);
    after_fall;
    check("R7 rd_valid after write edge", {35'd0, rd_valid}, 36'd0);
    step(1'b0, 1'b0, 6'd0, 4'h0, 36'h3_0303_0303);
    mupd(6'd30, 4'hF, 36'h3_0303_0303);
  endtask

  task automatic t_late_change;
    step(1'b1, 1'b0, 6'd21, 4'h0, JUNK);
    cs = 1'b1; we = 1'b1; addr = 6'd63; byte_en = 4'hF;   // changed after the edge
    after_fall;
    check("R1 late input change ignored", rd_data, model[21]);
    cs = 1'b0; we = 1'b0;
    step(1'b1, 1'b0, 6'd30, 4'h0, JUNK);
    after_fall;
    check("R6 full-lane write readback", rd_data, model[30]);
  endtask

  initial begin
    t_reset;
    t_single;
    t_coherent;
    t_back_to_back;
    t_deselect;
    t_late_change;
    step(1'b0, 1'b0, 6'd0, 4'h0, '0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule